// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave-side front end of a small three-wire serial nonvolatile memory. It runs on the serial clock and watches chip select and data-in. It waits for a start bit and then collects a four-bit command, an address and, for the two write-type commands, a data word. Once a command is complete, it issues a one-cycle request to a separate array sequencer. A read command instead fetches a word through a simple combinational read port and shifts it out on the data-out line.

A static organisation input selects the word shape. Wide mode has 64 words of 16 bits. Narrow mode has 128 words of 8 bits. The organisation therefore sets where each instruction ends.

Data-out is modelled as a value plus an output-enable. Before the read word, the block drives a zero for one cycle. The output returns to high impedance one edge after the last bit, or at once when chip select falls.

Top module: `mw_cmd_if`

## Requirements
- R1: No operation starts before a rising edge at which chip select and data-in are both high. Edges with chip select low, and edges with chip select high but data-in low before that start bit, have no effect.
- R2: The command field is the 4 bits after the start bit, first bit taken as bit 3. It decodes as follows, and `req_op` carries the code shown:
  - bit 2 set: write, code 0
  - bits 3..2 = 10: read (no request is issued)
  - 0011: enable, code 1
  - 0000: disable, code 2
  - 0010: erase-all, code 3
  - 0001: write-all, code 4
- R3: With `org_wide` high, the address has 6 bits and the data word has 16 bits. With it low, the address has 7 bits and the data word has 8 bits. Both fields are shifted in most significant bit first. A read therefore drives data-out for 17 cycles in wide mode and 9 cycles in narrow mode.
- R4: A request is a single-cycle `req_valid` pulse, with `req_op`, `req_addr` and `req_data`, in the cycle after the edge that samples its last required bit. For enable, disable and erase-all that bit is the last (don't-care) address bit; `req_data` is then zero. For write and write-all it is the last data bit.
- R5: For a read, the edge that samples the last address bit raises `rd_en` with the address on `rd_addr`, and turns on data-out driving a 0. Each later edge presents the next word bit, most significant first. In narrow mode only `rd_data[7:0]` is used.
- R6: Data-out returns to high impedance on the edge after the one that presented the last data bit.
- R7: When chip select is low, `do_oe` is low with no clock edge needed.
- R8: If chip select falls before an instruction is complete, the partial instruction is discarded and no request is issued.
- R9: After an instruction completes, further clock and data-in activity is ignored until chip select has been low at a rising edge and a new start bit arrives.
- R10: While `busy` is high at the completing edge, write, erase-all and write-all requests are dropped. Enable, disable and reads proceed.
- R11: After reset, `do_oe` and `req_valid` are low and the block waits for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| di | input | 1 | Serial data in |
| org_wide | input | 1 | Organisation: 1 = 64x16, 0 = 128x8 |
| busy | input | 1 | Sequencer busy with a programming cycle |
| rd_data | input | 16 | Word returned by the array for `rd_addr` |
| rd_en | output | 1 | Read fetch strobe, on the last address edge |
| rd_addr | output | 7 | Read address (upper bit zero in wide mode) |
| do_val | output | 1 | Serial data-out value, zero when not driven |
| do_oe | output | 1 | Data-out drive enable (low = high impedance) |
| req_valid | output | 1 | Single-cycle request strobe to the sequencer |
| req_op | output | 3 | Request code as listed in R2 |
| req_addr | output | 7 | Request address |
| req_data | output | 16 | Request data word (narrow mode in bits 7..0) |

## Verification
The bench aims at the frame boundary in each organisation. A design that used a fixed address width would issue requests one bit early or late in one of the two modes, and a read would shift out a word offset by a bit. Reads are cut short by chip select. If the output were not gated by chip select, it would keep driving after deselection, and an aborted write that was not discarded would reach the sequencer. Trailing bits after a finished command form a start bit and command patterns. A block that re-armed without a chip select drop would issue a second request. Frames sent while `busy` is high show whether only the write-type codes are dropped.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;
    localparam int ARRAY_BITS = 1024;
    localparam int WIDE_W     = 16;
    localparam int NARROW_W   = 8;
    localparam int CMD_W      = 4;
    localparam int WIDE_AW    = $clog2(ARRAY_BITS / WIDE_W);
    localparam int NARROW_AW  = $clog2(ARRAY_BITS / NARROW_W);
    localparam int CNT_W      = $clog2(WIDE_W + 1);

    typedef enum logic [2:0] {
        OP_WRITE = 3'd0,
        OP_EWEN  = 3'd1,
        OP_EWDS  = 3'd2,
        OP_ERAL  = 3'd3,
        OP_WRAL  = 3'd4,
        OP_READ  = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_CMD, PH_ADDR, PH_DATA, PH_DONE
    } phase_e;

    typedef struct packed {
        op_e                  op;
        logic [NARROW_AW-1:0] addr;
        logic [WIDE_W-1:0]    data;
    } req_t;

    function automatic op_e decode_cmd(input logic [CMD_W-1:0] c);
        if (c[2])      return OP_WRITE;
        else if (c[3]) return OP_READ;
        else begin
            case (c[1:0])
                2'b11:   return OP_EWEN;
                2'b00:   return OP_EWDS;
                2'b10:   return OP_ERAL;
                default: return OP_WRAL;
            endcase
        end
    endfunction

    function automatic logic carries_data(input op_e op);
        return (op == OP_WRITE) || (op == OP_WRAL);
    endfunction

    function automatic logic busy_guarded(input op_e op);
        return (op == OP_WRITE) || (op == OP_ERAL) || (op == OP_WRAL);
    endfunction
endpackage

// File: rtl/mw_frame_fsm.sv
`timescale 1ns/1ps
module mw_frame_fsm
    import mw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic di,
    input  logic org_wide,
    input  logic has_data,
    output logic shift_en,
    output logic last_cmd,
    output logic last_addr,
    output logic last_data
);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] WAW_LAST  = CNT_W'(WIDE_AW - 1);
    localparam logic [CNT_W-1:0] NAW_LAST  = CNT_W'(NARROW_AW - 1);
    localparam logic [CNT_W-1:0] WDW_LAST  = CNT_W'(WIDE_W - 1);
    localparam logic [CNT_W-1:0] NDW_LAST  = CNT_W'(NARROW_W - 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] aw_last, dw_last;

    always_comb begin
        aw_last   = org_wide ? WAW_LAST : NAW_LAST;
        dw_last   = org_wide ? WDW_LAST : NDW_LAST;
        last_cmd  = cs && (phase_q == PH_CMD)  && (cnt_q == CMD_LAST);
        last_addr = cs && (phase_q == PH_ADDR) && (cnt_q == aw_last);
        last_data = cs && (phase_q == PH_DATA) && (cnt_q == dw_last);
        shift_en  = cs && ((phase_q == PH_CMD) || (phase_q == PH_ADDR) ||
                           (phase_q == PH_DATA));
    end

    always_ff @(posedge clk) begin
        if (rst || !cs) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (di) begin
                    phase_q <= PH_CMD;
                    cnt_q   <= '0;
                end
                PH_CMD: if (last_cmd) begin
                    phase_q <= PH_ADDR;
                    cnt_q   <= '0;
                end else cnt_q <= cnt_q + 1'b1;
                PH_ADDR: if (last_addr) begin
                    phase_q <= has_data ? PH_DATA : PH_DONE;
                    cnt_q   <= '0;
                end else cnt_q <= cnt_q + 1'b1;
                PH_DATA: if (last_data) begin
                    phase_q <= PH_DONE;
                    cnt_q   <= '0;
                end else cnt_q <= cnt_q + 1'b1;
                default: phase_q <= PH_DONE;
            endcase
        end
    end
endmodule

// File: rtl/mw_rx_shift.sv
`timescale 1ns/1ps
module mw_rx_shift
    import mw_pkg::*;
#(
    parameter int SH_W = WIDE_W - 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  logic            di,
    output logic [SH_W-1:0] sh
);
    always_ff @(posedge clk) begin
        if (rst)           sh <= '0;
        else if (shift_en) sh <= {sh[SH_W-2:0], di};
    end
endmodule

// File: rtl/mw_tx_ser.sv
`timescale 1ns/1ps
module mw_tx_ser
    import mw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              org_wide,
    input  logic              load,
    input  logic [WIDE_W-1:0] word,
    output logic              do_val,
    output logic              do_oe
);
    localparam logic [CNT_W-1:0] WIDE_N   = CNT_W'(WIDE_W);
    localparam logic [CNT_W-1:0] NARROW_N = CNT_W'(NARROW_W);

    logic              act_q, bit_q;
    logic [WIDE_W-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  bits_n;
    logic [WIDE_W-1:0] aligned;

    always_comb begin
        bits_n  = org_wide ? WIDE_N : NARROW_N;
        aligned = org_wide ? word
                           : {word[NARROW_W-1:0], {(WIDE_W-NARROW_W){1'b0}}};
        do_oe   = act_q & cs;
        do_val  = do_oe & bit_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            bit_q <= 1'b0;
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            act_q <= 1'b1;
            bit_q <= 1'b0;
            sr_q  <= aligned;
            cnt_q <= '0;
        end else if (act_q) begin
            if (!cs || cnt_q == bits_n) begin
                act_q <= 1'b0;
            end else begin
                bit_q <= sr_q[WIDE_W-1];
                sr_q  <= sr_q << 1;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mw_cmd_if.sv
`timescale 1ns/1ps
module mw_cmd_if
    import mw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs,
    input  logic                 di,
    input  logic                 org_wide,
    input  logic                 busy,
    input  logic [WIDE_W-1:0]    rd_data,
    output logic                 rd_en,
    output logic [NARROW_AW-1:0] rd_addr,
    output logic                 do_val,
    output logic                 do_oe,
    output logic                 req_valid,
    output logic [2:0]           req_op,
    output logic [NARROW_AW-1:0] req_addr,
    output logic [WIDE_W-1:0]    req_data
);
    localparam int SH_W = WIDE_W - 1;

    logic                 shift_en, last_cmd, last_addr, last_data;
    logic [SH_W-1:0]      sh;
    logic [CMD_W-1:0]     cmd_q;
    logic [NARROW_AW-1:0] addr_q, addr_now;
    logic [WIDE_W-1:0]    data_now;
    op_e                  op;
    req_t                 req_q;
    logic                 valid_q;

    mw_frame_fsm u_fsm (
        .clk(clk), .rst(rst), .cs(cs), .di(di), .org_wide(org_wide),
        .has_data(carries_data(op)), .shift_en(shift_en),
        .last_cmd(last_cmd), .last_addr(last_addr), .last_data(last_data)
    );

    mw_rx_shift #(.SH_W(SH_W)) u_rx (
        .clk(clk), .rst(rst), .shift_en(shift_en), .di(di), .sh(sh)
    );

    mw_tx_ser u_tx (
        .clk(clk), .rst(rst), .cs(cs), .org_wide(org_wide),
        .load(rd_en), .word(rd_data), .do_val(do_val), .do_oe(do_oe)
    );

    always_comb begin
        op       = decode_cmd(cmd_q);
        addr_now = org_wide ? NARROW_AW'({sh[WIDE_AW-2:0], di})
                            : {sh[NARROW_AW-2:0], di};
        data_now = org_wide ? {sh[WIDE_W-2:0], di}
                            : WIDE_W'({sh[NARROW_W-2:0], di});
        rd_en    = last_addr && (op == OP_READ);
        rd_addr  = addr_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            addr_q  <= '0;
            valid_q <= 1'b0;
            req_q   <= '0;
        end else begin
            valid_q <= 1'b0;
            if (last_cmd)
                cmd_q <= {sh[CMD_W-2:0], di};
            if (last_addr) begin
                addr_q <= addr_now;
                if (op != OP_READ && !carries_data(op) &&
                    !(busy_guarded(op) && busy)) begin
                    valid_q <= 1'b1;
                    req_q   <= '{op: op, addr: addr_now, data: '0};
                end
            end
            if (last_data && !busy) begin
                valid_q <= 1'b1;
                req_q   <= '{op: op, addr: addr_q, data: data_now};
            end
        end
    end

    assign req_valid = valid_q;
    assign req_op    = req_q.op;
    assign req_addr  = req_q.addr;
    assign req_data  = req_q.data;
endmodule

// File: rtl/mw_cmd_if_chk.sv
`timescale 1ns/1ps
module mw_cmd_if_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs,
    input logic       busy,
    input logic       rd_en,
    input logic       do_oe,
    input logic       do_val,
    input logic       req_valid,
    input logic [2:0] req_op
);
    AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid); // R4

    AST_REQ_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $past(cs)); // R8

    AST_FETCH_STARTS_DRIVE: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (do_oe == cs)); // R5

    AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !do_val); // R5

    AST_DRIVE_ONLY_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
        (do_oe && !$past(do_oe)) |-> $past(rd_en)); // R5

    AST_BUSY_DROPS_PROGRAM: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_op == 3'd0 || req_op == 3'd3 || req_op == 3'd4))
            |-> !$past(busy)); // R10
endmodule

bind mw_cmd_if mw_cmd_if_chk u_chk (
    .clk(clk), .rst(rst), .cs(cs), .busy(busy), .rd_en(rd_en),
    .do_oe(do_oe), .do_val(do_val), .req_valid(req_valid), .req_op(req_op)
);

// File: tb/mw_cmd_if_tb.sv
`timescale 1ns/1ps
module mw_cmd_if_tb;
    logic        clk = 1'b0;
    logic        rst, cs, di, org_wide, busy;
    logic [15:0] rd_data;
    logic        rd_en, do_val, do_oe, req_valid;
    logic [6:0]  rd_addr, req_addr;
    logic [2:0]  req_op;
    logic [15:0] req_data;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] memf(input logic [6:0] a);
        return 16'h5A3C ^ {a, 9'h0} ^ {9'h0, a};
    endfunction
    assign rd_data = memf(rd_addr);

    mw_cmd_if u_dut (
        .clk(clk), .rst(rst), .cs(cs), .di(di), .org_wide(org_wide),
        .busy(busy), .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .do_val(do_val), .do_oe(do_oe), .req_valid(req_valid),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data)
    );

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model
    int          m_st, m_n, m_ri, m_dw, m_aw_now, m_dw_now, m_op;
    logic [31:0] m_acc;
    logic [3:0]  m_cmd;
    logic        m_oe, m_val, m_rv;
    logic [15:0] m_word, m_rdata;
    logic [6:0]  m_a, m_raddr;
    int          m_rop;

    function automatic int model_op(input logic [3:0] c);
        if (c[2]) return 0;
        if (c[3]) return 5;
        if (c == 4'b0011) return 1;
        if (c == 4'b0000) return 2;
        if (c == 4'b0010) return 3;
        return 4;
    endfunction

    task automatic issue(input int op, input logic [6:0] a, input logic [15:0] d);
        if (busy && (op == 0 || op == 3 || op == 4)) return;
        m_rv = 1'b1; m_rop = op; m_raddr = a; m_rdata = d;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_oe = 0; m_val = 0; m_rv = 0; m_n = 0; m_ri = 0;
            m_rop = 0; m_raddr = 0; m_rdata = 0; m_dw = 16; m_cmd = 0;
        end else begin
            m_aw_now = org_wide ? 6 : 7;
            m_dw_now = org_wide ? 16 : 8;
            m_rv = 1'b0;
            if (!cs) begin
                m_st = 0; m_oe = 0;
            end else begin
                if (m_oe) begin
                    if (m_ri == m_dw) m_oe = 0;
                    else begin m_val = m_word[m_dw-1-m_ri]; m_ri++; end
                end
                case (m_st)
                    0: if (di) begin m_st = 1; m_n = 0; m_acc = 0; end
                    1: begin
                        m_acc = {m_acc[30:0], di};
                        m_n++;
                        if (m_n == 4) m_cmd = m_acc[3:0];
                        if (m_n == 4 + m_aw_now) begin
                            m_a  = 7'(m_acc & ((32'd1 << m_aw_now) - 1));
                            m_op = model_op(m_cmd);
                            if (m_op == 5) begin
                                m_oe = 1; m_val = 0; m_ri = 0; m_dw = m_dw_now;
                                m_word = memf(m_a); m_st = 2;
                            end else if (m_op != 0 && m_op != 4) begin
                                issue(m_op, m_a, 16'h0); m_st = 2;
                            end
                        end
                        if (m_n == 4 + m_aw_now + m_dw_now) begin
                            issue(model_op(m_cmd), m_a,
                                  16'(m_acc & ((32'd1 << m_dw_now) - 1)));
                            m_st = 2;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison and monitors
    int          req_cnt = 0, oe_cnt = 0;
    logic [2:0]  last_op;
    logic [6:0]  last_addr;
    logic [15:0] last_data;
    always @(negedge clk) begin
        if (!rst) begin
            chk(do_oe === (m_oe && cs), "R6 drive enable", 32'(do_oe), 32'(m_oe && cs));
            if (m_oe && cs)
                chk(do_val === m_val, "R5 read bit", 32'(do_val), 32'(m_val));
            chk(req_valid === m_rv, "R4 request strobe", 32'(req_valid), 32'(m_rv));
            if (m_rv && req_valid) begin
                chk(req_op == 3'(m_rop), "R2 request code", 32'(req_op), 32'(m_rop));
                chk(req_addr == m_raddr, "R3 request address", 32'(req_addr), 32'(m_raddr));
                chk(req_data == m_rdata, "R3 request data", 32'(req_data), 32'(m_rdata));
            end
            if (req_valid) begin
                req_cnt++; last_op = req_op; last_addr = req_addr; last_data = req_data;
            end
            if (do_oe) oe_cnt++;
        end
    end

    task automatic bit_at(input logic c, input logic d);
        @(posedge clk); #1; cs = c; di = d;
    endtask

    task automatic frame(input logic [3:0] cmd, input logic [6:0] a,
                         input logic [15:0] d, input bit withd, input int extra);
        int aw, dw;
        aw = org_wide ? 6 : 7;
        dw = org_wide ? 16 : 8;
        bit_at(1, 1);
        for (int i = 3; i >= 0; i--) bit_at(1, cmd[i]);
        for (int i = aw - 1; i >= 0; i--) bit_at(1, a[i]);
        if (withd) for (int i = dw - 1; i >= 0; i--) bit_at(1, d[i]);
        for (int i = 0; i < extra; i++) bit_at(1, (i % 2) == 0);
        bit_at(0, 0);
        bit_at(0, 0);
    endtask

    int base;
    initial begin
        rst = 1; cs = 0; di = 0; org_wide = 1; busy = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(do_oe == 0 && req_valid == 0, "R11 reset state",
            32'({do_oe, req_valid}), 32'h0);

        // R1: data-in activity with chip select low does nothing
        for (int i = 0; i < 6; i++) bit_at(0, 1);
        bit_at(0, 0);
        chk(req_cnt == 0 && oe_cnt == 0, "R1 no start with select low", 32'(req_cnt), 32'h0);

        // R1: leading zeros with select high, then enable (wide)
        for (int i = 0; i < 5; i++) bit_at(1, 0);
        frame(4'b0011, 7'h15, 16'h0, 0, 0);
        chk(req_cnt == 1 && last_op == 3'd1, "R1 enable after leading zeros",
            32'(last_op), 32'd1);

        // R3: wide write
        frame(4'b0100, 7'h2A, 16'hBEEF, 1, 0);
        chk(last_op == 3'd0 && last_addr == 7'h2A && last_data == 16'hBEEF,
            "R3 wide write fields", {last_addr, last_data}, {7'h2A, 16'hBEEF});

        // R9: trailing bits after enable must not re-arm
        base = req_cnt;
        frame(4'b0011, 7'h00, 16'h0, 0, 12);
        chk(req_cnt == base + 1, "R9 trailing bits ignored", 32'(req_cnt), 32'(base + 1));

        // R3/R6: wide read drives 17 cycles
        oe_cnt = 0;
        frame(4'b1000, 7'h21, 16'h0, 0, 22);
        chk(oe_cnt == 17, "R3 wide read length", 32'(oe_cnt), 32'd17);

        // narrow organisation
        org_wide = 0;
        frame(4'b0111, 7'h55, 16'h00C3, 1, 0);
        chk(last_op == 3'd0 && last_addr == 7'h55 && last_data == 16'h00C3,
            "R3 narrow write fields", {last_addr, last_data}, {7'h55, 16'h00C3});
        oe_cnt = 0;
        frame(4'b1011, 7'h6B, 16'h0, 0, 14);
        chk(oe_cnt == 9, "R6 narrow read length", 32'(oe_cnt), 32'd9);
        frame(4'b0010, 7'h7F, 16'h0, 0, 0);
        chk(last_op == 3'd3, "R2 erase-all code", 32'(last_op), 32'd3);
        frame(4'b0001, 7'h11, 16'h003C, 1, 0);
        chk(last_op == 3'd4 && last_data == 16'h003C, "R2 write-all code",
            {last_op, last_data}, {3'd4, 16'h003C});
        frame(4'b0000, 7'h01, 16'h0, 0, 0);
        chk(last_op == 3'd2, "R2 disable code", 32'(last_op), 32'd2);

        // R8: partial write aborted
        base = req_cnt;
        bit_at(1, 1);
        for (int i = 3; i >= 0; i--) bit_at(1, i == 2);
        for (int i = 0; i < 9; i++) bit_at(1, 1);
        bit_at(0, 0); bit_at(0, 0);
        chk(req_cnt == base, "R8 partial discarded", 32'(req_cnt), 32'(base));

        // R7: read cut short by chip select
        org_wide = 1;
        bit_at(1, 1);
        for (int i = 3; i >= 0; i--) bit_at(1, i == 3);
        for (int i = 0; i < 6; i++) bit_at(1, i[0]);
        for (int i = 0; i < 4; i++) bit_at(1, 0);
        bit_at(0, 0);
        @(negedge clk);
        chk(do_oe == 0, "R7 select low releases output", 32'(do_oe), 32'h0);
        bit_at(0, 0);

        // R10: busy drops program requests only
        busy = 1;
        base = req_cnt;
        frame(4'b0100, 7'h0F, 16'h1234, 1, 0);
        frame(4'b0010, 7'h00, 16'h0, 0, 0);
        chk(req_cnt == base, "R10 write and erase dropped", 32'(req_cnt), 32'(base));
        frame(4'b0000, 7'h00, 16'h0, 0, 0);
        chk(req_cnt == base + 1 && last_op == 3'd2, "R10 disable passes",
            32'(last_op), 32'd2);
        oe_cnt = 0;
        frame(4'b1001, 7'h3E, 16'h0, 0, 20);
        chk(oe_cnt == 17, "R10 read while busy", 32'(oe_cnt), 32'd17);
        busy = 0;

        repeat (3) bit_at(0, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule